// File: doc/BRIEF.md
# Repeated-Subtraction Binary-to-Decimal Converter

This block turns a 16-bit unsigned binary value in the range 0 to 9999 into four BCD digits. It does not shift and add. It counts how many times each decimal weight fits into a working remainder. A one-cycle start request loads the value. The block then tries to take 1000 from the remainder once per clock. Each trial that does not borrow is kept and counted. The first trial that would borrow closes the stage, and the count becomes that digit. The same loop then runs for 100 and for 10. Whatever is left after the tens stage is the units digit.

The time a conversion takes depends on the value. A stage costs one cycle per successful subtraction plus one cycle for the trial that fails. A single-cycle done strobe marks the point where all four digits are valid. The digits then hold until another conversion finishes its stages. A start request that arrives during a conversion is dropped.

Top module: `rsb_bcd_conv`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy` and `done` are 0 and `bcd` reads 0.
- R2: When `start` is 1 on a clock edge with `busy` at 0, `value` is captured on that edge and `busy` reads 1 from that edge on.
- R3: The thousands digit (`bcd[15:12]`) equals the number of times 1000 can be subtracted from the captured value without borrowing.
- R4: The hundreds digit (`bcd[11:8]`) and the tens digit (`bcd[7:4]`) equal the counts of successful subtractions of 100 and 10 from the remainder left by the stage before.
- R5: The units digit (`bcd[3:0]`) equals the remainder left after the tens stage.
- R6: `done` rises exactly T+H+N+3 clock edges after the capture edge, where T, H and N are the thousands, hundreds and tens digits. Each trial subtraction takes one cycle, so the worst case is 30 cycles.
- R7: `done` is high for exactly one cycle. `busy` falls on the same edge where `done` rises.
- R8: `start` is ignored while `busy` is 1. Neither the result nor the latency of the running conversion changes.
- R9: After `done`, `bcd` keeps the result while `value` changes, until a new conversion is started.
- R10: No digit count ever goes past 9 for inputs within range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, used only when idle |
| value | input | 16 | Binary value to convert, 0 to 9999 |
| busy | output | 1 | A conversion is running |
| done | output | 1 | One-cycle strobe: all digits valid |
| bcd | output | 16 | Thousands in [15:12], hundreds [11:8], tens [7:4], units [3:0] |

## Verification
A stage sequencer that advances too early or too late shows up in two ways. The digit values are wrong, and `done` arrives on the wrong cycle. Because the latency is exactly T+H+N+3, an extra or missing trial is visible within one conversion as a shifted strobe. A wrong subtrahend or a counter that does not clear changes a digit on the first value that uses that stage, so the edge values 0, 9, 10, 999, 1000 and 9999 expose it. A start request that is not blocked while busy changes the captured value mid-flight, and the next digits reported show it.

// File: rtl/rsb_pkg.sv
// Package: shared sizes and the decimal-weight helper for the converter.
// Assumes NUM_DIG small enough that 10**(NUM_DIG-1) fits in 32 bits.
package rsb_pkg;
    localparam int VAL_W   = 16;  // binary input width
    localparam int DIG_W   = 4;   // width of one BCD digit
    localparam int NUM_DIG = 4;   // digits produced

    // Returns 10 raised to the given exponent.
    function automatic int pow10(input int e);
        int r;
        r = 1;
        for (int k = 0; k < e; k++) r = r * 10;
        return r;
    endfunction
endpackage

// File: rtl/rsb_trial.sv
// Trial subtractor: subtracts the decimal weight of the current stage from
// the remainder and flags a borrow. Purely combinational.
// Assumes stage < NUM_DIG-1 (the units digit has no stage of its own).
module rsb_trial #(
    parameter int VAL_W   = rsb_pkg::VAL_W,
    parameter int NUM_DIG = rsb_pkg::NUM_DIG,
    localparam int STG_W  = $clog2(NUM_DIG)
) (
    input  logic [VAL_W-1:0] rem,
    input  logic [STG_W-1:0] stage,
    output logic [VAL_W-1:0] diff,
    output logic             borrow
);
    logic [VAL_W-1:0] weight [NUM_DIG-1];

    // One constant weight per stage, largest first.
    for (genvar g = 0; g < NUM_DIG - 1; g++) begin : g_weight
        assign weight[g] = VAL_W'(rsb_pkg::pow10(NUM_DIG - 1 - g));
    end

    // Widened subtraction; the top bit is the borrow.
    always_comb begin
        {borrow, diff} = {1'b0, rem} - {1'b0, weight[stage]};
    end
endmodule

// File: rtl/rsb_seq.sv
// Stage sequencer: accepts a start when idle, then walks the stages. It moves
// on each time the trial borrows, and raises a one-cycle done after the last stage.
// Assumes borrow is the output of the trial subtractor for the current stage.
module rsb_seq #(
    parameter int NUM_DIG = rsb_pkg::NUM_DIG,
    localparam int STG_W  = $clog2(NUM_DIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             borrow,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             last_stage,
    output logic [STG_W-1:0] stage
);
    localparam logic [STG_W-1:0] LAST = STG_W'(NUM_DIG - 2);

    assign accept     = start && !busy;
    assign last_stage = (stage == LAST);

    // Sequencing of busy, stage and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            stage <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                stage <= '0;
            end else if (busy && borrow) begin
                if (last_stage) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    stage <= stage + 1'b1;
                end
            end
        end
    end

    // Done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Busy falls on the edge where done rises.
    assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    // A start while busy does not restart the stages.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !borrow) |=> $stable(stage));
    // An accepted start sets busy on the next cycle.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && stage == '0));
    // The stage index never goes past the last subtracting stage.
    always_comb begin
        if (rst_n) assert_stage_range_R6: assert (stage <= LAST);
    end
endmodule

// File: rtl/rsb_digits.sv
// Digit datapath: holds the remainder and the running count. It stores each
// count as a digit when its stage ends, and the final remainder as the units digit.
// Assumes the loaded value is at most 10**NUM_DIG - 1.
module rsb_digits #(
    parameter int VAL_W   = rsb_pkg::VAL_W,
    parameter int DIG_W   = rsb_pkg::DIG_W,
    parameter int NUM_DIG = rsb_pkg::NUM_DIG,
    localparam int STG_W  = $clog2(NUM_DIG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic                     busy,
    input  logic                     borrow,
    input  logic                     last_stage,
    input  logic [STG_W-1:0]         stage,
    input  logic [VAL_W-1:0]         value,
    input  logic [VAL_W-1:0]         diff,
    output logic [VAL_W-1:0]         rem,
    output logic [NUM_DIG*DIG_W-1:0] bcd
);
    logic [DIG_W-1:0] cnt;
    logic [DIG_W-1:0] dig [NUM_DIG];

    // Remainder and count: load on accept, commit on a trial with no borrow, clear count at stage end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            cnt <= '0;
        end else if (accept) begin
            rem <= value;
            cnt <= '0;
        end else if (busy) begin
            if (!borrow) begin
                rem <= diff;
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // Digit registers: a stage digit is written when its stage ends.
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dig[g] <= '0;
            end else if (busy && borrow) begin
                if (g < NUM_DIG - 1) begin
                    if (stage == STG_W'(g)) dig[g] <= cnt;
                end else if (last_stage) begin
                    dig[g] <= rem[DIG_W-1:0];
                end
            end
        end
        assign bcd[(NUM_DIG-1-g)*DIG_W +: DIG_W] = dig[g];
    end

    // A stage count stays a decimal digit.
    assert_count_decimal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= DIG_W'(9)));
    // When the units stage closes, the remainder is a single digit.
    assert_units_fit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && borrow && last_stage) |-> (rem < VAL_W'(10)));
    // Digits do not move while idle.
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> $stable(bcd));
endmodule

// File: rtl/rsb_bcd_conv.sv
// Top: repeated-subtraction binary-to-BCD converter. A stage sequencer drives a
// trial subtractor and a digit datapath, one trial subtraction per clock.
// Assumes value <= 9999 for the default four digits.
module rsb_bcd_conv #(
    parameter int VAL_W   = rsb_pkg::VAL_W,
    parameter int DIG_W   = rsb_pkg::DIG_W,
    parameter int NUM_DIG = rsb_pkg::NUM_DIG,
    localparam int STG_W  = $clog2(NUM_DIG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [VAL_W-1:0]         value,
    output logic                     busy,
    output logic                     done,
    output logic [NUM_DIG*DIG_W-1:0] bcd
);
    logic             accept;
    logic             borrow;
    logic             last_stage;
    logic [STG_W-1:0] stage;
    logic [VAL_W-1:0] rem;
    logic [VAL_W-1:0] diff;

    rsb_seq #(.NUM_DIG(NUM_DIG)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .borrow(borrow),
        .accept(accept), .busy(busy), .done(done),
        .last_stage(last_stage), .stage(stage)
    );

    rsb_trial #(.VAL_W(VAL_W), .NUM_DIG(NUM_DIG)) i_trial (
        .rem(rem), .stage(stage), .diff(diff), .borrow(borrow)
    );

    rsb_digits #(.VAL_W(VAL_W), .DIG_W(DIG_W), .NUM_DIG(NUM_DIG)) i_digits (
        .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
        .borrow(borrow), .last_stage(last_stage), .stage(stage),
        .value(value), .diff(diff), .rem(rem), .bcd(bcd)
    );

    // Reset leaves the outputs cleared.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && bcd == '0));
endmodule

// File: tb/test_rsb_bcd_conv.sv
// Bench: directed edge values plus seeded random values. The expected digits
// and latency are computed by bench functions.
module test_rsb_bcd_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] value = '0;
    logic        busy;
    logic        done;
    logic [15:0] bcd;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    rsb_bcd_conv i_rsb_bcd_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .value(value),
        .busy(busy), .done(done), .bcd(bcd)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            checks++;
            $display("FAIL R6 watchdog: actual %0d cycles expected < 150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] exp_bcd(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int exp_lat(input int v);
        return v / 1000 + (v / 100) % 10 + (v / 10) % 10 + 3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One conversion; optionally pulses start mid-run with another value (R8).
    task automatic convert(input int v, input bit poke);
        int cyc;
        @(negedge clk);
        value = 16'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 100) begin
            if (poke && cyc == 1) begin
                value = 16'((v + 4321) % 10000);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(bcd[15:12] == exp_bcd(v)[15:12], "R3 thousands", int'(bcd[15:12]), int'(exp_bcd(v)[15:12]));
        check(bcd[11:4] == exp_bcd(v)[11:4], "R4 hundreds/tens", int'(bcd[11:4]), int'(exp_bcd(v)[11:4]));
        check(bcd[3:0] == exp_bcd(v)[3:0], "R5 units", int'(bcd[3:0]), int'(exp_bcd(v)[3:0]));
        check(cyc == exp_lat(v), poke ? "R8 latency with start while busy" : "R6 latency",
              cyc, exp_lat(v));
        @(negedge clk);
        check(!done && !busy, "R7 done single cycle", int'({done, busy}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && bcd == 16'h0, "R1 reset state", int'({busy, done, bcd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && bcd == 16'h0, "R1 after release", int'({busy, done, bcd}), 0);

        convert(0, 1'b0);
        convert(9, 1'b0);
        convert(10, 1'b0);
        convert(999, 1'b0);
        convert(1000, 1'b0);
        convert(9999, 1'b0);
        convert(5050, 1'b1);
        convert(8765, 1'b1);

        // R9: the result holds while the input changes.
        value = 16'd1234;
        repeat (5) @(negedge clk);
        check(bcd == exp_bcd(8765), "R9 hold after done", int'(bcd), int'(exp_bcd(8765)));

        void'($urandom(32'd20240611));
        for (int i = 0; i < 300; i++) begin
            convert(int'($urandom % 10000), ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule